// File: doc/BRIEF.md
# Overcurrent Hiccup Switch Controller

This block makes the cycle-by-cycle switch decisions for one synchronous buck channel. A cycle-start tick from the oscillator and a set of digitized comparator flags come in. Two gate enables go out, one for the high-side switch and one for the low-side switch. The flags are a peak-current trip, a low-side source-limit flag, a low-side sink-limit flag, an overvoltage flag and an overvoltage-recovered flag. Cycles that end in overcurrent are counted. When the count reaches a limit, the channel stops switching for a long fixed number of cycles, which is called hiccup. It then retries inside a soft-start window. A separate overvoltage path discharges the output through the low-side switch and then holds both switches open until feedback has fallen back.

The controller is an enumerated state machine with seven states. ST_START is the post-reset wait for the first tick. ST_HS_ON and ST_LS_ON are the two halves of a switching cycle. ST_OFF_CYC keeps both switches open until the next tick. ST_HICCUP is the long off period. ST_OV_DISCH and ST_OV_HOLD form the overvoltage sequence. The transitions are:
- tick-start: ST_START or ST_OFF_CYC to ST_HS_ON.
- peak-trip: ST_HS_ON to ST_LS_ON.
- new-cycle: ST_HS_ON or ST_LS_ON to ST_HS_ON on a tick.
- source-skip: ST_LS_ON to ST_LS_ON on a tick while the source limit is high.
- sink-open: ST_LS_ON to ST_OFF_CYC.
- oc-limit: any switching state to ST_HICCUP.
- retry: ST_HICCUP to ST_HS_ON.
- ov-enter: any switching state to ST_OV_DISCH.
- ov-sink: ST_OV_DISCH to ST_OV_HOLD.
- ov-release: ST_OV_HOLD to ST_OFF_CYC.

A soft-start flag runs alongside the state machine. A registered interlock stage sits between the state decode and the gate outputs.

Top module: `ohc_hiccup_ctrl`

## Requirements
- R1: While the state machine is switching normally, a tick starts a cycle with the high-side switch on. A peak-current trip sampled while the high side is on and no tick is present turns the high side off. The low side then stays on for the rest of the cycle, and the trip adds one to the overcurrent count.
- R2: If the source-limit flag is high on a tick that ends a cycle with the low side on, that cycle is skipped. The high side stays off and the low side stays on until the next tick, and the skip adds one to the overcurrent count.
- R3: A tick that ends a cycle with neither a peak trip nor a skip clears the overcurrent count. Nine counted cycles followed by a clean cycle never cause hiccup.
- R4: When the count reaches OC_LIMIT (10), the block enters hiccup with both enables low and status[2] high. Hiccup lasts for HICCUP_CYC (4096) ticks. The last of those ticks starts a normal cycle with the high side on.
- R5: A sink-limit trip while the low side is on opens both switches, and they stay open until the next tick.
- R6: Leaving hiccup sets status[0] (soft-start). It clears on the SOFT_CYC-th (512th) tick after the retry tick. status[0] is never high together with status[2].
- R7: An overvoltage flag turns the high side off and the low side on, and ticks have no effect during this. A sink-limit trip then opens both switches, which stay open through ticks until the recovered flag is seen. The block then waits for the next tick and resumes switching. status[1] is high from the overvoltage flag until recovery.
- R8: hs_en and ls_en are never high in the same clock. Every change from one switch to the other passes through one clock with both low. Each enable follows the state by one register.
- R9: When flags coincide in one clock, the order is: count limit, then overvoltage, then tick, then the peak or sink trip. So an overvoltage with a tick enters the overvoltage sequence, and a tick with a sink trip starts a new cycle.
- R10: Reset drives both enables low and status to 3'b001. Both enables stay low until the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_tick | input | 1 | One-clock pulse at each switching-cycle start |
| peak_trip | input | 1 | High-side peak-current comparator flag |
| src_lim | input | 1 | Low-side source-limit flag |
| sink_lim | input | 1 | Low-side sink-limit flag |
| ov_trip | input | 1 | Output overvoltage flag |
| ov_clear | input | 1 | Feedback back below the recovery level |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| status | output | 3 | [2] hiccup, [1] overvoltage sequence, [0] soft-start |

## Verification
The cycle-start tick can arrive in the same clock as a comparator flag that also wants to move the state machine. Two such collisions are provoked on purpose. In the first, an overvoltage flag is driven together with the tick while the low side is on. The check is that the low side stays on with no dead clock and status[1] rises. In the second, a sink-limit trip is driven together with the tick, also with the low side on. The check is that the high side comes on two clocks later, which shows that the tick won over the sink trip.

// File: rtl/ohc_pkg.sv
package ohc_pkg;

    typedef enum logic [2:0] {
        ST_START    = 3'd0,
        ST_HS_ON    = 3'd1,
        ST_LS_ON    = 3'd2,
        ST_OFF_CYC  = 3'd3,
        ST_HICCUP   = 3'd4,
        ST_OV_DISCH = 3'd5,
        ST_OV_HOLD  = 3'd6
    } ohc_state_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } ohc_gate_req_t;

    localparam int STAT_SOFT = 0;
    localparam int STAT_OV   = 1;
    localparam int STAT_HIC  = 2;
    localparam int STAT_W    = 3;

endpackage

// File: rtl/ohc_tick_timer.sv
module ohc_tick_timer #(
    parameter int LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic at_end
);
    localparam int TW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [TW-1:0] cnt;

    // at_end flags the position of the final tick of the window
    assign at_end = (cnt == TW'(LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ohc_oc_counter.sv
module ohc_oc_counter #(
    parameter int OC_LIMIT = 10,
    localparam int CW = $clog2(OC_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          tick,
    input  logic          peak_evt,
    input  logic          skip_evt,
    output logic [CW-1:0] cnt,
    output logic          limit_hit
);
    // cyc_hit remembers whether the running cycle has been counted
    logic          cyc_hit;
    logic [CW-1:0] base;

    assign base      = cyc_hit ? cnt : '0;
    assign limit_hit = (cnt >= CW'(OC_LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cyc_hit <= 1'b0;
        end else if (flush) begin
            cnt     <= '0;
            cyc_hit <= 1'b0;
        end else if (tick) begin
            cnt     <= base + CW'(skip_evt);
            cyc_hit <= skip_evt;
        end else if (peak_evt) begin
            if (cnt != CW'(OC_LIMIT)) begin
                cnt <= cnt + 1'b1;
            end
            cyc_hit <= 1'b1;
        end
    end
endmodule

// File: rtl/ohc_gate_drv.sv
module ohc_gate_drv (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ohc_pkg::ohc_gate_req_t req,
    output logic                  hs_en,
    output logic                  ls_en
);
    // A request is granted only while the opposite switch is already open,
    // so every hand-over spends one clock with both enables low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_en <= 1'b0;
            ls_en <= 1'b0;
        end else begin
            hs_en <= req.hs & ~ls_en;
            ls_en <= req.ls & ~hs_en;
        end
    end
endmodule

// File: rtl/ohc_hiccup_ctrl.sv
module ohc_hiccup_ctrl #(
    parameter int OC_LIMIT   = 10,
    parameter int HICCUP_CYC = 4096,
    parameter int SOFT_CYC   = 512,
    localparam int CW = $clog2(OC_LIMIT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_tick,
    input  logic       peak_trip,
    input  logic       src_lim,
    input  logic       sink_lim,
    input  logic       ov_trip,
    input  logic       ov_clear,
    output logic       hs_en,
    output logic       ls_en,
    output logic [2:0] status
);
    import ohc_pkg::*;

    ohc_state_e     state, nxt;
    logic           ss_act;
    logic [CW-1:0]  oc_cnt;
    logic           oc_hit;
    logic           peak_evt, skip_evt, oc_flush;
    logic           hic_last, hic_end;
    logic           ss_tick, ss_last, ss_end;
    ohc_gate_req_t  req;

    // ---------------- event qualification ----------------
    assign peak_evt = (state == ST_HS_ON) && peak_trip && !cyc_tick
                      && !ov_trip && !oc_hit;
    assign skip_evt = (state == ST_LS_ON) && cyc_tick && src_lim
                      && !ov_trip && !oc_hit;
    assign oc_flush = oc_hit || (state == ST_HICCUP);

    assign hic_end  = (state == ST_HICCUP) && cyc_tick && hic_last;
    assign ss_tick  = cyc_tick && ss_act
                      && (state != ST_START) && (state != ST_HICCUP);
    assign ss_end   = ss_tick && ss_last;

    ohc_oc_counter #(.OC_LIMIT(OC_LIMIT)) i_oc_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (oc_flush),
        .tick      (cyc_tick),
        .peak_evt  (peak_evt),
        .skip_evt  (skip_evt),
        .cnt       (oc_cnt),
        .limit_hit (oc_hit)
    );

    ohc_tick_timer #(.LEN(HICCUP_CYC)) i_hic_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state != ST_HICCUP),
        .tick   (cyc_tick),
        .at_end (hic_last)
    );

    ohc_tick_timer #(.LEN(SOFT_CYC)) i_ss_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!ss_act || (state == ST_HICCUP)),
        .tick   (ss_tick),
        .at_end (ss_last)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_START;
            ss_act <= 1'b1;
        end else begin
            state <= nxt;
            if (hic_end) begin
                ss_act <= 1'b1;
            end else if ((nxt == ST_HICCUP) && (state != ST_HICCUP)) begin
                ss_act <= 1'b0;
            end else if (ss_end) begin
                ss_act <= 1'b0;
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            ST_START, ST_OFF_CYC: begin
                if (oc_hit)        nxt = ST_HICCUP;
                else if (ov_trip)  nxt = ST_OV_DISCH;
                else if (cyc_tick) nxt = ST_HS_ON;
            end
            ST_HS_ON: begin
                if (oc_hit)         nxt = ST_HICCUP;
                else if (ov_trip)   nxt = ST_OV_DISCH;
                else if (cyc_tick)  nxt = ST_HS_ON;
                else if (peak_trip) nxt = ST_LS_ON;
            end
            ST_LS_ON: begin
                if (oc_hit)        nxt = ST_HICCUP;
                else if (ov_trip)  nxt = ST_OV_DISCH;
                else if (cyc_tick) nxt = src_lim ? ST_LS_ON : ST_HS_ON;
                else if (sink_lim) nxt = ST_OFF_CYC;
            end
            ST_HICCUP: begin
                if (hic_end) nxt = ST_HS_ON;
            end
            ST_OV_DISCH: begin
                if (sink_lim) nxt = ST_OV_HOLD;
            end
            ST_OV_HOLD: begin
                if (ov_clear) nxt = ST_OFF_CYC;
            end
            default: nxt = ST_START;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        req.hs = 1'b0;
        req.ls = 1'b0;
        status = '0;
        unique case (state)
            ST_HS_ON:    req.hs = 1'b1;
            ST_LS_ON:    req.ls = 1'b1;
            ST_OV_DISCH: begin
                req.ls          = 1'b1;
                status[STAT_OV] = 1'b1;
            end
            ST_OV_HOLD:  status[STAT_OV]  = 1'b1;
            ST_HICCUP:   status[STAT_HIC] = 1'b1;
            default: ;
        endcase
        status[STAT_SOFT] = ss_act;
    end

    ohc_gate_drv i_gate_drv (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .hs_en (hs_en),
        .ls_en (ls_en)
    );
endmodule

// File: rtl/ohc_hiccup_ctrl_chk.sv
module ohc_hiccup_ctrl_chk #(
    parameter int OC_LIMIT = 10,
    localparam int CW = $clog2(OC_LIMIT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hs_en,
    input logic          ls_en,
    input logic [2:0]    status,
    input logic [CW-1:0] oc_cnt
);
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en)); // R8

    AST_DEAD_AFTER_LS: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en |=> !hs_en); // R8

    AST_DEAD_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |=> !ls_en); // R8

    AST_HICCUP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && $past(status[2])) |-> (!hs_en && !ls_en)); // R4

    AST_OV_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && $past(status[1])) |-> !hs_en); // R7

    AST_SOFT_NOT_HICCUP: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[2] && status[0])); // R6

    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[2:1])); // R9

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        oc_cnt <= CW'(OC_LIMIT)); // R3
endmodule

bind ohc_hiccup_ctrl ohc_hiccup_ctrl_chk #(.OC_LIMIT(OC_LIMIT)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_en  (hs_en),
    .ls_en  (ls_en),
    .status (status),
    .oc_cnt (oc_cnt)
);

// File: tb/test_ohc_hiccup_ctrl.sv
module test_ohc_hiccup_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_tick = 1'b0, peak_trip = 1'b0, src_lim = 1'b0;
    logic sink_lim = 1'b0, ov_trip = 1'b0, ov_clear = 1'b0;
    logic hs_en, ls_en;
    logic [2:0] status;
    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    ohc_hiccup_ctrl i_ohc_hiccup_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .peak_trip(peak_trip),
        .src_lim(src_lim), .sink_lim(sink_lim), .ov_trip(ov_trip),
        .ov_clear(ov_clear), .hs_en(hs_en), .ls_en(ls_en), .status(status)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_at(output int dummy);
        dummy = 0;
    endtask

    // One switching cycle of six clocks; starts and ends at a falling edge.
    task automatic run_cycle(input bit trip, input bit src);
        cyc_tick = 1'b1; src_lim = src;
        @(negedge clk); cyc_tick = 1'b0; src_lim = 1'b0;
        @(negedge clk); peak_trip = trip;
        @(negedge clk); peak_trip = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 hs in reset", hs_en, 0);
        check("R10 ls in reset", ls_en, 0);
        check("R10 status in reset", status, 3'b001);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 hs before first tick", hs_en, 0);
        check("R10 ls before first tick", ls_en, 0);
    endtask

    task automatic t_basic();
        cyc_tick = 1'b1;
        @(negedge clk); cyc_tick = 1'b0;
        check("R8 hs one register after tick", hs_en, 0);
        @(negedge clk);
        check("R1 hs on at cycle start", hs_en, 1);
        peak_trip = 1'b1;
        @(negedge clk); peak_trip = 1'b0;
        check("R8 hs still on one clock after trip", hs_en, 1);
        @(negedge clk);
        check("R8 dead clock hs", hs_en, 0);
        check("R8 dead clock ls", ls_en, 0);
        @(negedge clk);
        check("R1 ls on after trip", ls_en, 1);
        @(negedge clk);
        check("R1 ls holds rest of cycle", ls_en, 1);
        check("R1 hs off rest of cycle", hs_en, 0);
    endtask

    task automatic t_sink();
        run_cycle(1'b1, 1'b0);
        check("R5 ls on before sink trip", ls_en, 1);
        sink_lim = 1'b1;
        @(negedge clk); sink_lim = 1'b0;
        @(negedge clk);
        check("R5 ls opened by sink trip", ls_en, 0);
        repeat (3) @(negedge clk);
        check("R5 hs open until tick", hs_en, 0);
        check("R5 ls open until tick", ls_en, 0);
        run_cycle(1'b0, 1'b0);
        check("R5 hs back after tick", hs_en, 1);
    endtask

    task automatic t_skip();
        run_cycle(1'b1, 1'b0);
        run_cycle(1'b0, 1'b1);
        check("R2 skip keeps ls on", ls_en, 1);
        check("R2 skip keeps hs off", hs_en, 0);
        run_cycle(1'b0, 1'b0);
        check("R2 hs back after skip", hs_en, 1);
    endtask

    task automatic t_count_clear();
        int hic = 0;
        run_cycle(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) begin
            run_cycle(1'b1, 1'b0);
            hic |= status[2];
        end
        run_cycle(1'b0, 1'b0);
        hic |= status[2];
        for (int i = 0; i < 9; i++) begin
            run_cycle(1'b1, 1'b0);
            hic |= status[2];
        end
        check("R3 no hiccup with cleared count", hic, 0);
        run_cycle(1'b0, 1'b0);
        check("R3 clean cycle keeps hs on", hs_en, 1);
    endtask

    task automatic t_ov();
        ov_trip = 1'b1;
        @(negedge clk); ov_trip = 1'b0;
        check("R7 ov status set", status[1], 1);
        @(negedge clk);
        check("R7 hs opened by ov", hs_en, 0);
        @(negedge clk);
        check("R7 ls discharging", ls_en, 1);
        cyc_tick = 1'b1;
        @(negedge clk); cyc_tick = 1'b0;
        @(negedge clk);
        check("R7 tick ignored in discharge", ls_en, 1);
        sink_lim = 1'b1;
        @(negedge clk); sink_lim = 1'b0;
        @(negedge clk);
        check("R7 hold ls open", ls_en, 0);
        check("R7 hold hs open", hs_en, 0);
        cyc_tick = 1'b1;
        @(negedge clk); cyc_tick = 1'b0;
        @(negedge clk);
        check("R7 tick ignored in hold", hs_en, 0);
        check("R7 ov status in hold", status[1], 1);
        ov_clear = 1'b1;
        @(negedge clk); ov_clear = 1'b0;
        check("R7 ov status cleared", status[1], 0);
        run_cycle(1'b0, 1'b0);
        check("R7 switching resumes", hs_en, 1);
    endtask

    task automatic t_priority();
        run_cycle(1'b1, 1'b0);
        cyc_tick = 1'b1; ov_trip = 1'b1;
        @(negedge clk); cyc_tick = 1'b0; ov_trip = 1'b0;
        @(negedge clk);
        check("R9 ov beats tick ls", ls_en, 1);
        check("R9 ov beats tick hs", hs_en, 0);
        check("R9 ov beats tick status", status[1], 1);
        sink_lim = 1'b1;
        @(negedge clk); sink_lim = 1'b0; ov_clear = 1'b1;
        @(negedge clk); ov_clear = 1'b0;
        run_cycle(1'b1, 1'b0);
        cyc_tick = 1'b1; sink_lim = 1'b1;
        @(negedge clk); cyc_tick = 1'b0; sink_lim = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 tick beats sink trip", hs_en, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_hiccup_soft();
        int bad = 0;
        run_cycle(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) run_cycle(1'b1, 1'b0);
        run_cycle(1'b0, 1'b1);
        check("R2 skip counted, no hiccup yet", status[2], 0);
        run_cycle(1'b1, 1'b0);
        check("R4 hiccup entered", status[2], 1);
        check("R4 hiccup hs", hs_en, 0);
        check("R4 hiccup ls", ls_en, 0);
        for (int i = 0; i < 4095; i++) begin
            run_cycle(1'b0, 1'b0);
            if (hs_en || ls_en || !status[2]) bad++;
        end
        check("R4 hiccup held 4095 ticks", bad, 0);
        run_cycle(1'b0, 1'b0);
        check("R4 hiccup left", status[2], 0);
        check("R4 retry hs on", hs_en, 1);
        check("R6 soft-start set", status[0], 1);
        bad = 0;
        for (int i = 0; i < 511; i++) begin
            run_cycle(1'b0, 1'b0);
            if (!status[0]) bad++;
        end
        check("R6 soft-start over 511 ticks", bad, 0);
        run_cycle(1'b0, 1'b0);
        check("R6 soft-start ends at 512", status[0], 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        repeat (2) @(negedge clk);
        t_sink();
        t_skip();
        t_count_clear();
        t_ov();
        t_priority();
        t_hiccup_soft();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule